// File: doc/BRIEF.md
# Nested Digital Delay-Lock Loop Controller

This block closes the control loops of an all-digital delay-locked loop made of two nested calibration stages. A bang-bang phase detector outside the block compares the delay-line output edge with the next reference edge. It reports each comparison as a strobe and a direction bit, where "early" means the line is too short. For each stage, the controller integrates these decisions in a saturating up/down accumulator. This accumulator takes the place of an analog charge pump and loop filter. Only the upper bits of the accumulator leave the block, as the control word of a digitally controlled delay line. The low bits absorb the dither of the bang-bang loop.

The middle stage sets the coarse per-stage delay. The fine stage trims inside it. The fine stage is parked at its mid code and ignores its detector until the middle stage reports lock. It is parked again as soon as that lock is lost. Each stage has a lock watcher that declares lock after a run of comparisons in which the control word stays within one code of a reference. Both loops aim for a total line delay of one fast-clock period, for example 1.6 ns at 625 MHz.

Top module: `dll_nest_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets both accumulators to mid-scale, 2^(ACC_W-1). Both control words then read 2^(CODE_W-1), which is 16 with the defaults, and all lock outputs are low.
- R2: A middle strobe (`en` and `mid_vld` high) adds one to the middle accumulator when `mid_early` is 1 and subtracts one when it is 0. `mid_code` is the accumulator shifted right by ACC_W-CODE_W bits, which is 3 with the defaults.
- R3: Both accumulators saturate. They stay at 2^ACC_W-1 under further early strobes and at 0 under further late strobes.
- R4: While `en` is low, all strobes are ignored. `mid_code` holds its value, and `mid_lock` is low from the next edge on.
- R5: Each stage keeps a reference code. On every strobe of that stage, a new code within one code of the reference advances a run counter, which saturates at LOCK_CNT (default 16). Any other code clears the counter and becomes the new reference. The stage's lock output is high exactly while the counter equals LOCK_CNT.
- R6: While `mid_lock` is low, the fine accumulator is held at mid-scale, `fine_code` reads 16, and fine strobes have no effect.
- R7: While `mid_lock` is high, fine strobes (`en` and `fine_vld`) move the fine accumulator and its lock watcher by the same rules as R2, R3 and R5.
- R8: One edge after `mid_lock` reads low, `fine_code` is back at 16 and `fine_lock` is low. The fine reference returns to 16.
- R9: `lock` is high only when `mid_lock` and `fine_lock` are both high.
- R10: When the block is driven in closed loop by a delay line whose delay grows with both codes, both stages reach lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Loop enable; low ignores strobes and drops lock |
| mid_vld | input | 1 | Middle-stage comparison strobe |
| mid_early | input | 1 | Middle decision: 1 early (lengthen), 0 late (shorten) |
| fine_vld | input | 1 | Fine-stage comparison strobe |
| fine_early | input | 1 | Fine decision: 1 early (lengthen), 0 late (shorten) |
| mid_code | output | CODE_W | Middle delay-line control word |
| fine_code | output | CODE_W | Fine delay-line control word |
| mid_lock | output | 1 | Middle stage locked |
| fine_lock | output | 1 | Fine stage locked |
| lock | output | 1 | Both stages locked |

## Verification
The accumulator's low bits are not visible at the ports. An off-by-one step or a missed saturation therefore first shows up as a wrong code edge: a control word changes one strobe early or late, up to 2^(ACC_W-CODE_W) strobes after the fault. A corrupted reference or run counter shows up as a lock flag that rises one or more strobes off the expected count, or that fails to fall on the first out-of-band strobe. A faulty parking path shows up as a fine code other than mid-code on the edge right after `mid_lock` reads low. The bench compares all five outputs against an arithmetic model at every cycle, so each of these faults is reported on the cycle it first reaches a port.

// File: rtl/dll_nest_pkg.sv
package dll_nest_pkg;

  // True when two codes differ by at most one step.
  function automatic logic within_one(int a, int b);
    return ((a - b) <= 1) && ((b - a) <= 1);
  endfunction

endpackage

// File: rtl/dll_step_acc.sv
module dll_step_acc #(
  parameter int ACC_W  = 8,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              park,
  input  logic              step,
  input  logic              early,
  output logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] code_nxt
);

  localparam logic [ACC_W-1:0] ACC_MID = ACC_W'(1) << (ACC_W - 1);
  localparam logic [ACC_W-1:0] ACC_TOP = '1;

  function automatic logic [ACC_W-1:0] sat_move(logic [ACC_W-1:0] v, logic up);
    if (up) return (v == ACC_TOP) ? v : v + 1'b1;
    else    return (v == '0)      ? v : v - 1'b1;
  endfunction

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_move;
  logic             hit_rail;

  assign acc_move = sat_move(acc_q, early);
  assign hit_rail = early ? (acc_q == ACC_TOP) : (acc_q == '0);
  assign code     = acc_q[ACC_W-1 -: CODE_W];
  assign code_nxt = step ? acc_move[ACC_W-1 -: CODE_W] : code;

  always_ff @(posedge clk) begin
    if (rst || park)  acc_q <= ACC_MID;
    else if (step)    acc_q <= acc_move;
  end

  assert_rail_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (step && !park && hit_rail) |=> $stable(acc_q));

  assert_step_up_R2: assert property (@(posedge clk) disable iff (rst)
    (step && !park && !hit_rail && early) |=> (acc_q == $past(acc_q) + 1'b1));

  assert_step_down_R2: assert property (@(posedge clk) disable iff (rst)
    (step && !park && !hit_rail && !early) |=> (acc_q == $past(acc_q) - 1'b1));

  assert_park_mid_R6: assert property (@(posedge clk) disable iff (rst)
    park |=> (acc_q == ACC_MID));

endmodule

// File: rtl/dll_lock_watch.sv
module dll_lock_watch #(
  parameter int CODE_W   = 5,
  parameter int LOCK_CNT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              step,
  input  logic [CODE_W-1:0] code_nxt,
  input  logic [CODE_W-1:0] reload,
  output logic              locked
);

  localparam int              CNT_W    = $clog2(LOCK_CNT + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(LOCK_CNT);
  localparam logic [CODE_W-1:0] REF_MID = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] ref_q;
  logic [CNT_W-1:0]  run_q;
  logic              in_band;
  logic              slip;

  assign in_band = dll_nest_pkg::within_one(int'(code_nxt), int'(ref_q));
  assign slip    = step && !in_band;
  assign locked  = (run_q == CNT_FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= REF_MID;
      run_q <= '0;
    end else if (clear) begin
      ref_q <= reload;
      run_q <= '0;
    end else if (step) begin
      if (in_band) begin
        run_q <= (run_q == CNT_FULL) ? run_q : run_q + 1'b1;
      end else begin
        ref_q <= code_nxt;
        run_q <= '0;
      end
    end
  end

  assert_slip_unlocks_R5: assert property (@(posedge clk) disable iff (rst)
    (slip && !clear) |=> !locked);

  assert_lock_on_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(step));

  assert_clear_unlocks_R4: assert property (@(posedge clk) disable iff (rst)
    clear |=> !locked);

endmodule

// File: rtl/dll_nest_ctrl.sv
module dll_nest_ctrl #(
  parameter int ACC_W    = 8,
  parameter int CODE_W   = 5,
  parameter int LOCK_CNT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              mid_vld,
  input  logic              mid_early,
  input  logic              fine_vld,
  input  logic              fine_early,
  output logic [CODE_W-1:0] mid_code,
  output logic [CODE_W-1:0] fine_code,
  output logic              mid_lock,
  output logic              fine_lock,
  output logic              lock
);

  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  // Named loop events
  logic              mid_step;
  logic              mid_clear;
  logic              fine_step;
  logic              fine_park;
  logic              fine_clear;
  logic [CODE_W-1:0] mid_code_nxt;
  logic [CODE_W-1:0] fine_code_nxt;
  logic [CODE_W-1:0] fine_reload;

  assign mid_step    = en && mid_vld;
  assign mid_clear   = !en;
  assign fine_park   = !mid_lock;
  assign fine_step   = en && fine_vld && mid_lock;
  assign fine_clear  = !en || !mid_lock;
  assign fine_reload = mid_lock ? fine_code : MID_CODE;

  dll_step_acc #(.ACC_W(ACC_W), .CODE_W(CODE_W)) u_mid_acc (
    .clk(clk), .rst(rst), .park(1'b0), .step(mid_step), .early(mid_early),
    .code(mid_code), .code_nxt(mid_code_nxt)
  );

  dll_lock_watch #(.CODE_W(CODE_W), .LOCK_CNT(LOCK_CNT)) u_mid_watch (
    .clk(clk), .rst(rst), .clear(mid_clear), .step(mid_step),
    .code_nxt(mid_code_nxt), .reload(mid_code), .locked(mid_lock)
  );

  dll_step_acc #(.ACC_W(ACC_W), .CODE_W(CODE_W)) u_fine_acc (
    .clk(clk), .rst(rst), .park(fine_park), .step(fine_step), .early(fine_early),
    .code(fine_code), .code_nxt(fine_code_nxt)
  );

  dll_lock_watch #(.CODE_W(CODE_W), .LOCK_CNT(LOCK_CNT)) u_fine_watch (
    .clk(clk), .rst(rst), .clear(fine_clear), .step(fine_step),
    .code_nxt(fine_code_nxt), .reload(fine_reload), .locked(fine_lock)
  );

  assign lock = mid_lock && fine_lock;

  assert_fine_park_R8: assert property (@(posedge clk) disable iff (rst)
    !mid_lock |=> (fine_code == MID_CODE && !fine_lock));

  assert_en_freeze_R4: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(mid_code));

  assert_fine_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (!mid_lock && !$past(mid_lock)) |-> (fine_code == MID_CODE));

endmodule

// File: tb/dll_nest_ctrl_bench.sv
module dll_nest_ctrl_bench;

  localparam int ACC_W = 8, CODE_W = 5, LOCK_CNT = 16;
  localparam int SH = ACC_W - CODE_W;
  localparam int A_MID = 1 << (ACC_W - 1);
  localparam int A_TOP = (1 << ACC_W) - 1;
  localparam int C_MID = 1 << (CODE_W - 1);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, en, mid_vld, mid_early, fine_vld, fine_early;
  logic [CODE_W-1:0] mid_code, fine_code;
  logic mid_lock, fine_lock, lock;

  dll_nest_ctrl #(.ACC_W(ACC_W), .CODE_W(CODE_W), .LOCK_CNT(LOCK_CNT)) u_dll_nest_ctrl (
    .clk(clk), .rst(rst), .en(en), .mid_vld(mid_vld), .mid_early(mid_early),
    .fine_vld(fine_vld), .fine_early(fine_early), .mid_code(mid_code),
    .fine_code(fine_code), .mid_lock(mid_lock), .fine_lock(fine_lock), .lock(lock)
  );

  int m_acc, m_ref, m_cnt, f_acc, f_ref, f_cnt;
  int n_chk = 0, n_fail = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic advance(inout int acc, inout int rf, inout int cn, input bit up);
    int na, nc;
    na = up ? ((acc < A_TOP) ? acc + 1 : acc) : ((acc > 0) ? acc - 1 : acc);
    nc = na >> SH;
    if ((nc - rf) <= 1 && (rf - nc) <= 1) cn = (cn < LOCK_CNT) ? cn + 1 : cn;
    else begin cn = 0; rf = nc; end
    acc = na;
  endtask

  task automatic model(bit r, bit e, bit mv, bit me, bit fv, bit fe);
    bit ml_old;
    ml_old = (m_cnt == LOCK_CNT);
    if (r) begin
      m_acc = A_MID; f_acc = A_MID; m_ref = C_MID; f_ref = C_MID; m_cnt = 0; f_cnt = 0;
    end else begin
      if (!ml_old) begin f_acc = A_MID; f_cnt = 0; f_ref = C_MID; end
      else if (!e) begin f_cnt = 0; f_ref = f_acc >> SH; end
      else if (fv) advance(f_acc, f_ref, f_cnt, fe);
      if (!e) begin m_cnt = 0; m_ref = m_acc >> SH; end
      else if (mv) advance(m_acc, m_ref, m_cnt, me);
    end
  endtask

  // R2 R3 R5 R6 R7 R8 R9: every output against the model
  task automatic cmp_all();
    bit ml, fl;
    ml = (m_cnt == LOCK_CNT);
    fl = (f_cnt == LOCK_CNT);
    chk("R2/R3", "mid_code", int'(mid_code), m_acc >> SH);
    chk("R6/R7/R8", "fine_code", int'(fine_code), f_acc >> SH);
    chk("R5", "mid_lock", int'(mid_lock), int'(ml));
    chk("R5/R7", "fine_lock", int'(fine_lock), int'(fl));
    chk("R9", "lock", int'(lock), int'(ml && fl));
  endtask

  task automatic tick(bit r, bit e, bit mv, bit me, bit fv, bit fe);
    rst = r; en = e; mid_vld = mv; mid_early = me; fine_vld = fv; fine_early = fe;
    model(r, e, mv, me, fv, fe);
    @(negedge clk);
    cmp_all();
  endtask

  task automatic closed_loop(int mid_ps, int cycles, bit sparse);
    for (int i = 0; i < cycles; i++) begin
      bit early, v;
      early = (int'(mid_code) * mid_ps + int'(fine_code) * 5) < 1600;
      v = sparse ? (i % 2 == 0) : 1'b1;
      tick(0, 1, v, early, v, early);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #600000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int hold_m;
    rst = 1; en = 0; mid_vld = 0; mid_early = 0; fine_vld = 0; fine_early = 0;
    m_acc = 0; f_acc = 0; m_ref = 0; f_ref = 0; m_cnt = 0; f_cnt = 0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) tick(1, 0, 0, 0, 0, 0);
    // R1 reset state
    chk("R1", "mid_code", int'(mid_code), 16);
    chk("R1", "fine_code", int'(fine_code), 16);
    chk("R1", "locks", int'({mid_lock, fine_lock, lock}), 0);

    // R5: alternating decisions keep the code in band; lock after exactly 16 strobes
    for (int i = 0; i < 15; i++) tick(0, 1, 1, i % 2 == 0, 1, 1);
    chk("R5", "mid_lock after 15", int'(mid_lock), 0);
    chk("R6", "fine parked before lock", int'(fine_code), 16);
    tick(0, 1, 1, 0, 1, 1);
    chk("R5", "mid_lock after 16", int'(mid_lock), 1);

    // R2: unit steps, code is acc >> 3
    for (int i = 0; i < 3; i++) tick(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 7; i++) tick(0, 1, 1, 1, 1, 0);
    chk("R2", "7 early steps", int'(mid_code), 16);
    tick(0, 1, 1, 1, 1, 0);
    chk("R2", "8 early steps", int'(mid_code), 17);
    for (int i = 0; i < 9; i++) tick(0, 1, 1, 0, 1, 0);
    chk("R2", "9 late steps", int'(mid_code), 15);

    // R3: saturation at both rails
    for (int i = 0; i < 300; i++) tick(0, 1, 1, 1, 1, 1);
    chk("R3", "top rail", int'(mid_code), 31);
    chk("R3", "fine top rail", int'(fine_code), 31);
    for (int i = 0; i < 300; i++) tick(0, 1, 1, 0, 1, 0);
    chk("R3", "bottom rail", int'(mid_code), 0);

    // R4: enable low ignores strobes
    hold_m = int'(mid_code);
    for (int i = 0; i < 20; i++) tick(0, 0, 1, 1, 1, 1);
    chk("R4", "mid held", int'(mid_code), hold_m);
    chk("R4", "mid_lock low", int'(mid_lock), 0);
    chk("R8", "fine parked", int'(fine_code), 16);

    // R10 closed loop with several stage delays and strobe densities
    for (int k = 0; k < 4; k++) begin
      int ps;
      ps = (k == 0) ? 60 : (k == 1) ? 70 : (k == 2) ? 85 : 100;
      for (int i = 0; i < 2; i++) tick(1, 0, 0, 0, 0, 0);
      closed_loop(ps, 1500, k % 2 == 1);
      chk("R10", "lock reached", int'(lock), 1);
      // R8: push the middle loop out of band
      for (int i = 0; i < 40; i++) tick(0, 1, 1, 1, 0, 0);
      chk("R8", "fine back at mid", int'(fine_code), 16);
      chk("R8", "fine_lock low", int'(fine_lock), 0);
    end
    summary();
  end

endmodule